// File: doc/BRIEF.md
# Port Error Status and Interrupt Unit

This block gathers the error events of one storage host port and turns them into sticky status flags, a stop-processing request and a registered interrupt line. It sees single-cycle event pulses from the rest of the port: a host-memory abort with its later completion, host-memory data errors tagged with the structure being accessed, fatal and non-fatal link errors, task-file errors, overflows and frames whose port-select field was not in the expected set. Software clears each flag by writing a one to it, enables each cause separately, enables interrupts globally and owns a run bit.

A four-state controller decides when the port must stop. In `ST_STOPPED` the run bit is low. `ST_STOPPED -> ST_RUNNING` happens when the run bit rises. `ST_RUNNING -> ST_STOPPED` happens when the run bit drops. `ST_RUNNING -> ST_ABORTING` happens on a memory abort, and `ST_RUNNING -> ST_HALTED` happens on any other halting error. `ST_ABORTING -> ST_HALTED` happens when the transfer abort completes, and this is the cycle that sets the host-abort flag. `ST_HALTED -> ST_STOPPED` happens once software drops the run bit. The stop request is high in `ST_ABORTING` and `ST_HALTED`.

When per-device switching is on, task-file errors and overflows record the device number and raise a single-device-error flag. They do not halt the whole port. A payload data error that is allowed to continue raises a one-cycle request to corrupt the CRC of the outgoing data frame.

Top module: `port_err_unit`

## Requirements
- R1: After reset, `flags`, `irq`, `stop_req`, `crc_poison`, `err_dev` and `sde` are all zero and the controller is in `ST_STOPPED`.
- R2: Flags are sticky. A one in `flag_clr` clears the matching flag at the next edge. An event and a clear of the same flag in one cycle leave the flag set.
- R3: `mem_abort` while running moves to `ST_ABORTING` and asserts `stop_req` from the next cycle. The host-abort flag (bit 0) is set only at the edge where `abort_done` arrives in `ST_ABORTING`, which also moves to `ST_HALTED`.
- R4: `irq` is registered. It equals `glob_ien` AND the OR of (`flags` AND `flag_ien`) as they stood one cycle earlier, so it rises two edges after an enabled event.
- R5: `mem_data_err` always sets the data-error flag (bit 1). The location codes are: `mem_err_loc` 0 payload, 1 command frame, 2 descriptor entry, 3 command list. A code of 1, 2 or 3 while running moves to `ST_HALTED`.
- R6: With `PAYLOAD_ERR_HALT`=0, a payload data error (location 0) while running does not halt. It makes `crc_poison` high for exactly the next cycle.
- R7: `link_fatal` sets bit 2 and, while running, halts. `link_nonfatal` sets bit 3 and never halts.
- R8: An accepted `tf_err` sets bit 4. With `dev_switch_en`=0 and `flag_ien[4]`=1 while running, it halts the port.
- R9: With `dev_switch_en`=1, an accepted `tf_err` or an `ovf_evt` (which sets bit 5) loads `evt_dev` into `err_dev` and sets `sde`, and causes no halt. `err_dev` holds its value otherwise.
- R10: `psel_miss` sets bit 6. A `tf_err` in the same cycle is dropped: it sets no bit 4, records no device and causes no halt.
- R11: `stop_req` stays high in `ST_HALTED` until `run_en` is low at an edge, and is low in the next cycle (`ST_STOPPED`).
- R12: Flag bit positions are: 0 host abort, 1 host data error, 2 fatal link, 3 non-fatal link, 4 task-file, 5 overflow, 6 port-select mismatch.
- R13: `sde` is cleared by `sde_clr`. A recording event in the same cycle wins and leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Software run bit |
| mem_abort | input | 1 | Host-memory abort detected (pulse) |
| abort_done | input | 1 | Transfer abort finished (pulse) |
| mem_data_err | input | 1 | Host-memory data error (pulse) |
| mem_err_loc | input | 2 | Location of the data error (R5 encoding) |
| link_fatal | input | 1 | Fatal link error (pulse) |
| link_nonfatal | input | 1 | Non-fatal link error (pulse) |
| tf_err | input | 1 | Task-file update with error status (pulse) |
| ovf_evt | input | 1 | Command table overflow (pulse) |
| psel_miss | input | 1 | Port-select mismatch on received frame (pulse) |
| evt_dev | input | DEV_W | Device number tied to the current event |
| dev_switch_en | input | 1 | Per-device switching enabled |
| flag_ien | input | 7 | Per-flag interrupt enables |
| glob_ien | input | 1 | Global interrupt enable |
| flag_clr | input | 7 | Write-one-to-clear strobes for the flags |
| sde_clr | input | 1 | Clear strobe for the single-device-error flag |
| flags | output | 7 | Sticky status flags |
| irq | output | 1 | Interrupt request |
| stop_req | output | 1 | Stop processing commands |
| crc_poison | output | 1 | Corrupt CRC of outgoing data frame |
| err_dev | output | DEV_W | Device number of the last recorded error |
| sde | output | 1 | Single-device-error flag |

## Verification
On every cycle the assertions check the following:
- the host-abort flag is only set together with abort completion;
- a fetch error or a fatal link error while running leads to `ST_HALTED`;
- the stop request is released once the run bit drops;
- flags never drop without a clear;
- the interrupt is silent whenever the global enable was low;
- the device record moves only on a recording event.

Only the bench's scenarios can show the cross-cause behaviour: the halt choice under switching on and off, the dropped task-file error beside a port-select mismatch, set-over-clear collisions, and the two-cycle interrupt latency. These are compared against a reference model under directed and random event mixes.

// File: rtl/perr_pkg.sv
package perr_pkg;
    localparam int NFLAG = 7;

    localparam int FL_HOSTABT = 0;
    localparam int FL_HOSTDAT = 1;
    localparam int FL_LINKFTL = 2;
    localparam int FL_LINKNF  = 3;
    localparam int FL_TASKF   = 4;
    localparam int FL_OVFL    = 5;
    localparam int FL_PSEL    = 6;

    typedef enum logic [1:0] {
        LOC_PAYLOAD = 2'd0,
        LOC_CMDFIS  = 2'd1,
        LOC_DESC    = 2'd2,
        LOC_CLIST   = 2'd3
    } err_loc_e;

    typedef enum logic [1:0] {
        ST_STOPPED  = 2'd0,
        ST_RUNNING  = 2'd1,
        ST_ABORTING = 2'd2,
        ST_HALTED   = 2'd3
    } port_state_e;
endpackage

// File: rtl/perr_ctrl.sv
module perr_ctrl
    import perr_pkg::*;
#(
    parameter bit PAYLOAD_ERR_HALT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             mem_abort,
    input  logic             abort_done,
    input  logic             mem_data_err,
    input  logic [1:0]       mem_err_loc,
    input  logic             link_fatal,
    input  logic             link_nonfatal,
    input  logic             tf_err,
    input  logic             ovf_evt,
    input  logic             psel_miss,
    input  logic             dev_switch_en,
    input  logic             tf_ien,
    output logic [NFLAG-1:0] set_vec,
    output logic             stop_req,
    output logic             crc_poison,
    output logic             dev_rec_we
);
    port_state_e state_q, state_d;
    err_loc_e    loc;
    logic        tf_accept;
    logic        fetch_err;
    logic        payload_err;
    logic        halt_req;

    assign loc         = err_loc_e'(mem_err_loc);
    assign tf_accept   = tf_err && !psel_miss;
    assign fetch_err   = mem_data_err && (loc != LOC_PAYLOAD);
    assign payload_err = mem_data_err && (loc == LOC_PAYLOAD);
    assign halt_req    = fetch_err
                       || (payload_err && PAYLOAD_ERR_HALT)
                       || link_fatal
                       || (tf_accept && !dev_switch_en && tf_ien);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: begin
                if (run_en) state_d = ST_RUNNING;
            end
            ST_RUNNING: begin
                if (!run_en)        state_d = ST_STOPPED;
                else if (mem_abort) state_d = ST_ABORTING;
                else if (halt_req)  state_d = ST_HALTED;
            end
            ST_ABORTING: begin
                if (abort_done) state_d = ST_HALTED;
            end
            ST_HALTED: begin
                if (!run_en) state_d = ST_STOPPED;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        stop_req              = (state_q == ST_ABORTING) || (state_q == ST_HALTED);
        set_vec               = '0;
        set_vec[FL_HOSTABT]   = (state_q == ST_ABORTING) && abort_done;
        set_vec[FL_HOSTDAT]   = mem_data_err;
        set_vec[FL_LINKFTL]   = link_fatal;
        set_vec[FL_LINKNF]    = link_nonfatal;
        set_vec[FL_TASKF]     = tf_accept;
        set_vec[FL_OVFL]      = ovf_evt;
        set_vec[FL_PSEL]      = psel_miss;
        dev_rec_we            = dev_switch_en && (tf_accept || ovf_evt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_poison <= 1'b0;
        else        crc_poison <= (state_q == ST_RUNNING) && payload_err && !PAYLOAD_ERR_HALT;
    end

    // R3
    hbf_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[FL_HOSTABT] |-> (abort_done && stop_req));

    // R5
    fetch_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUNNING && run_en && !mem_abort && mem_data_err && mem_err_loc != 2'd0)
        |=> (state_q == ST_HALTED));

    // R7
    link_fatal_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUNNING && run_en && !mem_abort && link_fatal) |=> stop_req);

    // R11
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALTED && !run_en) |=> !stop_req);

    // R6
    poison_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_poison |-> ($past(mem_data_err) && $past(mem_err_loc) == 2'd0));
endmodule

// File: rtl/perr_flags.sv
module perr_flags
    import perr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_vec,
    input  logic [NFLAG-1:0] clr_vec,
    output logic [NFLAG-1:0] q
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= set_vec[i] || (q[i] && !clr_vec[i]);
        end

        // R2
        flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> q[i]);

        // R2
        flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (q[i] && !clr_vec[i]) |=> q[i]);
    end
endmodule

// File: rtl/perr_irq.sv
module perr_irq
    import perr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] flags,
    input  logic [NFLAG-1:0] ien,
    input  logic             glob_ien,
    output logic             irq
);
    logic any_cause;
    assign any_cause = |(flags & ien);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= glob_ien && any_cause;
    end

    // R4
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_ien |=> !irq);
endmodule

// File: rtl/perr_devrec.sv
module perr_devrec #(
    parameter int DEV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [DEV_W-1:0] dev_in,
    input  logic             sde_clr,
    output logic [DEV_W-1:0] err_dev,
    output logic             sde
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_dev <= '0;
            sde     <= 1'b0;
        end else begin
            if (we) err_dev <= dev_in;
            sde <= we || (sde && !sde_clr);
        end
    end

    // R9
    dev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(err_dev));

    // R13
    sde_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> sde);
endmodule

// File: rtl/port_err_unit.sv
module port_err_unit
    import perr_pkg::*;
#(
    parameter int DEV_W            = 4,
    parameter bit PAYLOAD_ERR_HALT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             mem_abort,
    input  logic             abort_done,
    input  logic             mem_data_err,
    input  logic [1:0]       mem_err_loc,
    input  logic             link_fatal,
    input  logic             link_nonfatal,
    input  logic             tf_err,
    input  logic             ovf_evt,
    input  logic             psel_miss,
    input  logic [DEV_W-1:0] evt_dev,
    input  logic             dev_switch_en,
    input  logic [NFLAG-1:0] flag_ien,
    input  logic             glob_ien,
    input  logic [NFLAG-1:0] flag_clr,
    input  logic             sde_clr,
    output logic [NFLAG-1:0] flags,
    output logic             irq,
    output logic             stop_req,
    output logic             crc_poison,
    output logic [DEV_W-1:0] err_dev,
    output logic             sde
);
    logic [NFLAG-1:0] set_vec;
    logic             dev_rec_we;

    perr_ctrl #(.PAYLOAD_ERR_HALT(PAYLOAD_ERR_HALT)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_en       (run_en),
        .mem_abort    (mem_abort),
        .abort_done   (abort_done),
        .mem_data_err (mem_data_err),
        .mem_err_loc  (mem_err_loc),
        .link_fatal   (link_fatal),
        .link_nonfatal(link_nonfatal),
        .tf_err       (tf_err),
        .ovf_evt      (ovf_evt),
        .psel_miss    (psel_miss),
        .dev_switch_en(dev_switch_en),
        .tf_ien       (flag_ien[FL_TASKF]),
        .set_vec      (set_vec),
        .stop_req     (stop_req),
        .crc_poison   (crc_poison),
        .dev_rec_we   (dev_rec_we)
    );

    perr_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(set_vec),
        .clr_vec(flag_clr),
        .q      (flags)
    );

    perr_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags   (flags),
        .ien     (flag_ien),
        .glob_ien(glob_ien),
        .irq     (irq)
    );

    perr_devrec #(.DEV_W(DEV_W)) u_devrec (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (dev_rec_we),
        .dev_in (evt_dev),
        .sde_clr(sde_clr),
        .err_dev(err_dev),
        .sde    (sde)
    );
endmodule

// File: tb/port_err_unit_test.sv
module port_err_unit_test;
    import perr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEV_W      = 4;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic             rst_n;
    logic             run_en, mem_abort, abort_done, mem_data_err;
    logic [1:0]       mem_err_loc;
    logic             link_fatal, link_nonfatal, tf_err, ovf_evt, psel_miss;
    logic [DEV_W-1:0] evt_dev;
    logic             dev_switch_en, glob_ien, sde_clr;
    logic [NFLAG-1:0] flag_ien, flag_clr;
    logic [NFLAG-1:0] flags;
    logic             irq, stop_req, crc_poison, sde;
    logic [DEV_W-1:0] err_dev;

    port_err_unit #(.DEV_W(DEV_W), .PAYLOAD_ERR_HALT(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .mem_abort(mem_abort),
        .abort_done(abort_done), .mem_data_err(mem_data_err), .mem_err_loc(mem_err_loc),
        .link_fatal(link_fatal), .link_nonfatal(link_nonfatal), .tf_err(tf_err),
        .ovf_evt(ovf_evt), .psel_miss(psel_miss), .evt_dev(evt_dev),
        .dev_switch_en(dev_switch_en), .flag_ien(flag_ien), .glob_ien(glob_ien),
        .flag_clr(flag_clr), .sde_clr(sde_clr), .flags(flags), .irq(irq),
        .stop_req(stop_req), .crc_poison(crc_poison), .err_dev(err_dev), .sde(sde)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // reference model state (0 stopped, 1 running, 2 aborting, 3 halted)
    logic [NFLAG-1:0] m_flags;
    logic             m_irq, m_poison, m_sde;
    logic [DEV_W-1:0] m_dev;
    int               m_st;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic m_stop();
        return (m_st == 2) || (m_st == 3);
    endfunction

    task automatic model_step();
        logic [NFLAG-1:0] setv;
        logic tf_ok, halt, rec;
        int   nst;
        tf_ok = tf_err && !psel_miss;
        halt  = (mem_data_err && mem_err_loc != 2'd0) || link_fatal
              || (tf_ok && !dev_switch_en && flag_ien[4]);
        rec   = dev_switch_en && (tf_ok || ovf_evt);
        setv  = '0;
        setv[0] = (m_st == 2) && abort_done;
        setv[1] = mem_data_err;
        setv[2] = link_fatal;
        setv[3] = link_nonfatal;
        setv[4] = tf_ok;
        setv[5] = ovf_evt;
        setv[6] = psel_miss;
        nst = m_st;
        case (m_st)
            0: if (run_en) nst = 1;
            1: if (!run_en) nst = 0; else if (mem_abort) nst = 2; else if (halt) nst = 3;
            2: if (abort_done) nst = 3;
            default: if (!run_en) nst = 0;
        endcase
        m_poison = (m_st == 1) && mem_data_err && (mem_err_loc == 2'd0);
        m_irq    = glob_ien && (|(m_flags & flag_ien));
        m_flags  = (m_flags & ~flag_clr) | setv;
        if (rec) m_dev = evt_dev;
        m_sde    = rec || (m_sde && !sde_clr);
        m_st     = nst;
    endtask

    task automatic compare_all();
        chk("R2 flags", 32'(flags), 32'(m_flags));
        chk("R4 irq", 32'(irq), 32'(m_irq));
        chk("R11 stop_req", 32'(stop_req), 32'(m_stop()));
        chk("R6 crc_poison", 32'(crc_poison), 32'(m_poison));
        chk("R9 err_dev", 32'(err_dev), 32'(m_dev));
        chk("R13 sde", 32'(sde), 32'(m_sde));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic clr_ev();
        mem_abort = 0; abort_done = 0; mem_data_err = 0; link_fatal = 0;
        link_nonfatal = 0; tf_err = 0; ovf_evt = 0; psel_miss = 0;
        flag_clr = '0; sde_clr = 0;
    endtask

    task automatic recover();
        run_en = 0;
        cyc();
        run_en = 1;
        flag_clr = '1;
        cyc();
        clr_ev();
        cyc();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 0; run_en = 0; mem_err_loc = 0; evt_dev = 0;
        dev_switch_en = 0; glob_ien = 1; flag_ien = '1;
        clr_ev();
        m_flags = '0; m_irq = 0; m_poison = 0; m_sde = 0; m_dev = '0; m_st = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 flags", 32'(flags), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 stop_req", 32'(stop_req), 0);
        chk("R1 crc_poison", 32'(crc_poison), 0);
        chk("R1 err_dev", 32'(err_dev), 0);
        chk("R1 sde", 32'(sde), 0);

        run_en = 1;
        cyc();

        // R2 / R12: set and clear in same cycle, bit 3
        link_nonfatal = 1; flag_clr = 7'h08;
        cyc(); clr_ev();
        chk("R2 set wins", 32'(flags), 32'h08);
        chk("R12 nonfatal bit3", 32'(flags[3]), 1);
        cyc();
        chk("R4 irq after two edges", 32'(irq), 1);
        flag_clr = 7'h08;
        cyc(); clr_ev();
        chk("R2 cleared", 32'(flags), 0);
        chk("R7 nonfatal no halt", 32'(stop_req), 0);
        cyc();
        chk("R4 irq dropped", 32'(irq), 0);

        // R3 abort sequence
        mem_abort = 1;
        cyc(); clr_ev();
        chk("R3 stop on abort", 32'(stop_req), 1);
        chk("R3 no flag yet", 32'(flags[0]), 0);
        cyc(); cyc();
        chk("R3 still waiting", 32'(flags[0]), 0);
        abort_done = 1;
        cyc(); clr_ev();
        chk("R3 flag on done", 32'(flags), 32'h01);
        cyc();
        chk("R11 stop held", 32'(stop_req), 1);
        run_en = 0;
        cyc();
        chk("R11 stop released", 32'(stop_req), 0);
        run_en = 1; flag_clr = '1;
        cyc(); clr_ev(); cyc();

        // R5 fetch-location data error halts
        mem_data_err = 1; mem_err_loc = 2'd2;
        cyc(); clr_ev();
        chk("R5 halt on descriptor", 32'(stop_req), 1);
        chk("R5 data flag", 32'(flags[1]), 1);
        recover();

        // R6 payload error continues and poisons CRC
        mem_data_err = 1; mem_err_loc = 2'd0;
        cyc(); clr_ev();
        chk("R6 poison", 32'(crc_poison), 1);
        chk("R6 no halt", 32'(stop_req), 0);
        cyc();
        chk("R6 poison one cycle", 32'(crc_poison), 0);
        recover();

        // R7 fatal link halts
        link_fatal = 1;
        cyc(); clr_ev();
        chk("R7 fatal halt", 32'(stop_req), 1);
        chk("R7 fatal bit2", 32'(flags), 32'h04);
        recover();

        // R8 task-file error halts without switching
        tf_err = 1;
        cyc(); clr_ev();
        chk("R8 tf halt", 32'(stop_req), 1);
        chk("R8 tf bit4", 32'(flags), 32'h10);
        recover();

        // R9 per-device recording
        dev_switch_en = 1; evt_dev = 4'd5; tf_err = 1;
        cyc(); clr_ev();
        chk("R9 dev recorded", 32'(err_dev), 5);
        chk("R9 sde set", 32'(sde), 1);
        chk("R9 no halt", 32'(stop_req), 0);
        evt_dev = 4'd9; ovf_evt = 1;
        cyc(); clr_ev();
        chk("R9 ovf dev", 32'(err_dev), 9);
        chk("R12 ovf bit5", 32'(flags[5]), 1);
        flag_clr = '1;
        cyc(); clr_ev();

        // R10 port-select mismatch drops same-cycle task-file error
        psel_miss = 1; tf_err = 1; evt_dev = 4'd3;
        cyc(); clr_ev();
        chk("R10 only psel flag", 32'(flags), 32'h40);
        chk("R10 dev unchanged", 32'(err_dev), 9);
        chk("R10 no halt", 32'(stop_req), 0);

        // R13 sde set wins over clear
        sde_clr = 1; ovf_evt = 1; evt_dev = 4'd2;
        cyc(); clr_ev();
        chk("R13 sde set wins", 32'(sde), 1);
        sde_clr = 1;
        cyc(); clr_ev();
        chk("R13 sde cleared", 32'(sde), 0);
        dev_switch_en = 0;
        recover();

        // random phase
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            run_en        = ($urandom % 32) != 0;
            mem_abort     = ($urandom % 12) == 0;
            abort_done    = ($urandom % 4) == 0;
            mem_data_err  = ($urandom % 10) == 0;
            mem_err_loc   = 2'($urandom);
            link_fatal    = ($urandom % 14) == 0;
            link_nonfatal = ($urandom % 8) == 0;
            tf_err        = ($urandom % 8) == 0;
            ovf_evt       = ($urandom % 10) == 0;
            psel_miss     = ($urandom % 10) == 0;
            evt_dev       = DEV_W'($urandom);
            if (($urandom % 64) == 0) dev_switch_en = ~dev_switch_en;
            if (($urandom % 32) == 0) flag_ien = NFLAG'($urandom);
            glob_ien      = ($urandom % 16) != 0;
            flag_clr      = (($urandom % 4) == 0) ? NFLAG'($urandom) : '0;
            sde_clr       = ($urandom % 8) == 0;
            cyc();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule